// File: doc/BRIEF.md
# Receive Sync-to-Async Rate Converter

This block sits behind a synchronous receiver. It takes one received bit per bit-rate strobe and rebuilds start/stop characters for a terminal on a serial output. A far-end sender whose clock runs a little fast may drop a stop bit now and then to keep pace. The converter detects this case, because a low level appears where the stop bit should be, and puts the missing stop bit back on its output. To stay ahead of a fast sender, the output runs slightly above the nominal rate. Its bit timing comes from a 16x oversample enable, and bit periods are shortened in a fixed pattern. An extended mode replaces that pattern with stop bits at 7/8 width.

Received characters pass through a four-entry queue between the input framer and the output serializer. A line held low for two character frames is treated as a break: the output goes low and stays low, and no stop bit is inserted into it. A bypass control, used for FSK and synchronous operation, routes the input level straight to the output and stops all framing.

Top module: `rx_sync2async`

## Requirements
- R1: After reset, and whenever no character or break is being sent, `ser_out` is high and `overrun` is low.
- R2: `len_sel` values 0, 1, 2 and 3 select frames of 8, 9, 10 and 11 bits. A frame is one low start bit, then `len_sel+6` payload bits sent LSB first, then one high stop bit. The input is sampled only on `bit_stb`, and the output frame has the same layout as the input frame.
- R3: If the stop slot of a received character is low, that low bit is taken as the start bit of the next character. The output still sends the first character with a high stop bit.
- R4: With `ext_mode` low, each output bit lasts 16 oversample ticks, except that every 8th output bit lasts 15 ticks. The counting uses a running count of output bits since reset; the bit whose count is 7 mod 8 is the short one. This holds the rate within +1%.
- R5: With `ext_mode` high, stop bits last 14 ticks, all other bits last 16 ticks, and the running count of R4 does not advance. The overspeed stays within +2.3%.
- R6: When another character is queued at the end of a stop bit, its start bit begins on the very next tick.
- R7: A break is 2N-1 low samples in a row, where N is the frame length: a character with all payload bits low and a low stop slot, followed by a second such character whose stop slot is also low. On a break, neither character is emitted. Once the queue has drained, `ser_out` is held low with no high pulse. It returns high after the first high input sample.
- R8: A character with all payload bits low and a low stop slot is emitted, in order, once a later high input sample rules out a break. This includes the case where that high sample is the stop bit of a following all-low character, so both characters enter the queue in the same cycle.
- R9: The queue holds 4 characters. A character that arrives while the queue is full is dropped, and `overrun` goes high and stays high until reset.
- R10: While `bypass` is high, `ser_out` equals `bit_in` in the same cycle, and input samples queue nothing.
- R11: The output serializer advances only on cycles where `os_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe at the received bit rate |
| bit_in | input | 1 | Received data bit, sampled when `bit_stb` is high |
| os_en | input | 1 | 16x oversample enable for output timing |
| len_sel | input | 2 | Frame length select (8 to 11 bits) |
| ext_mode | input | 1 | Extended overspeed: stop bits at 7/8 width |
| bypass | input | 1 | Route `bit_in` straight to `ser_out` |
| ser_out | output | 1 | Asynchronous character output |
| overrun | output | 1 | Sticky queue overflow flag |

## Verification
The framer can release a deferred all-low character in the same cycle that it completes the following character, which means two writes into the queue on one edge. The bench provokes this with an all-low character that lacks its stop bit, followed by an all-low character that has one. It passes only if two all-low frames appear back to back, in order, with correct stop bits. A second coincidence is queue fill against overflow. With `os_en` held low, five characters are pushed: the flag must stay clear after the fourth and must rise on the fifth, and exactly the first four characters must drain afterwards.

// File: rtl/rs2a_pkg.sv
package rs2a_pkg;
  localparam int MAXPAY = 9;

  // payload bits between start and stop for a given length select
  function automatic int pay_len(input logic [1:0] sel);
    return int'(sel) + 6;
  endfunction

  // oversample ticks for one output bit
  function automatic logic [4:0] bit_ticks(input logic ext, input logic is_stop,
                                           input logic short_slot);
    if (ext && is_stop) return 5'd14;
    else if (!ext && short_slot) return 5'd15;
    else return 5'd16;
  endfunction

  // move a payload shifted in from the top down to bit 0
  function automatic logic [MAXPAY-1:0] align_pay(input logic [MAXPAY-1:0] sh,
                                                  input logic [1:0] sel);
    return sh >> (MAXPAY - pay_len(sel));
  endfunction
endpackage

// File: rtl/rs2a_deframer.sv
module rs2a_deframer
  import rs2a_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic [1:0]        len_sel,
  input  logic              bypass,
  output logic [1:0]        n_push,
  output logic [MAXPAY-1:0] d0,
  output logic [MAXPAY-1:0] d1,
  output logic              brk
);
  typedef enum logic [1:0] {S_HUNT, S_DATA, S_STOP, S_BRK} df_st_t;
  df_st_t            st;
  logic [3:0]        cnt;
  logic [MAXPAY-1:0] sh;
  logic              held;
  logic [MAXPAY-1:0] cur;
  logic              cur_nz;
  logic [3:0]        last_idx;

  assign cur      = align_pay(sh, len_sel);
  assign cur_nz   = |sh;
  assign last_idx = 4'(pay_len(len_sel) - 1);
  assign brk      = (st == S_BRK);

  always_comb begin
    n_push = 2'd0;
    d0     = cur;
    d1     = cur;
    if (bit_stb && !bypass) begin
      case (st)
        S_DATA: if (bit_in && held) begin n_push = 2'd1; d0 = '0; end
        S_STOP: begin
          if (bit_in) begin
            n_push = held ? 2'd2 : 2'd1;
            if (held) d0 = '0;
          end else if (cur_nz) begin
            n_push = 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HUNT; cnt <= '0; sh <= '0; held <= 1'b0;
    end else if (bypass) begin
      st <= S_HUNT; held <= 1'b0;
    end else if (bit_stb) begin
      case (st)
        S_HUNT: if (!bit_in) begin st <= S_DATA; cnt <= '0; sh <= '0; end
        S_DATA: begin
          sh <= {bit_in, sh[MAXPAY-1:1]};
          if (bit_in) held <= 1'b0;
          if (cnt == last_idx) st <= S_STOP;
          else cnt <= cnt + 4'd1;
        end
        S_STOP: begin
          if (bit_in) begin
            st <= S_HUNT; held <= 1'b0;
          end else if (cur_nz) begin
            st <= S_DATA; cnt <= '0; sh <= '0;
          end else if (held) begin
            st <= S_BRK; held <= 1'b0;
          end else begin
            held <= 1'b1; st <= S_DATA; cnt <= '0; sh <= '0;
          end
        end
        default: if (bit_in) st <= S_HUNT;
      endcase
    end
  end

  p_no_push_in_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRK) |-> (n_push == 2'd0));
  p_bypass_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (n_push == 2'd0));
endmodule

// File: rtl/rs2a_fifo.sv
module rs2a_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   n_push,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         overrun
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, free;
  logic          acc0, acc1, ovr_ev;

  assign free    = (AW+1)'(DEPTH) - cnt;
  assign acc0    = (n_push != 2'd0) && (free != '0);
  assign acc1    = (n_push == 2'd2) && (int'(free) > 1);
  assign ovr_ev  = int'(n_push) > int'(free);
  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (acc0) mem[wp] <= d0;
    if (acc1) mem[wp + AW'(1)] <= d1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; overrun <= 1'b0;
    end else begin
      wp  <= wp + AW'(acc0) + AW'(acc1);
      if (pop) rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(acc0) + (AW+1)'(acc1) - (AW+1)'(pop);
      if (ovr_ev) overrun <= 1'b1;
    end
  end

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/rs2a_tx.sv
module rs2a_tx
  import rs2a_pkg::*;
#(
  parameter int K_NORM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_en,
  input  logic              ext,
  input  logic [1:0]        len_sel,
  input  logic              empty,
  input  logic [MAXPAY-1:0] rd_data,
  input  logic              brk,
  output logic              pop,
  output logic              tx_q
);
  localparam int FW = MAXPAY + 1;
  localparam int SW = $clog2(K_NORM);
  logic          busy;
  logic [3:0]    bi;
  logic [4:0]    tc;
  logic [FW-1:0] fr;
  logic [SW-1:0] slot;
  logic          is_stop, bit_end;
  logic [4:0]    len;

  assign is_stop = (bi == 4'(pay_len(len_sel) + 1));
  assign len     = bit_ticks(ext, is_stop, slot == SW'(K_NORM - 1));
  assign bit_end = busy && (tc == len - 5'd1);
  assign pop     = os_en && !empty && (!busy || (bit_end && is_stop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bi <= '0; tc <= '0; fr <= '0; slot <= '0; tx_q <= 1'b1;
    end else if (os_en) begin
      if (bit_end && !ext) slot <= slot + SW'(1);
      if (pop) begin
        busy <= 1'b1; bi <= '0; tc <= '0; tx_q <= 1'b0;
        fr   <= {1'b0, rd_data} | (FW'(1) << pay_len(len_sel));
      end else if (bit_end) begin
        if (is_stop) begin
          busy <= 1'b0; tx_q <= ~brk;
        end else begin
          bi <= bi + 4'd1; tc <= '0; tx_q <= fr[0]; fr <= fr >> 1;
        end
      end else if (busy) begin
        tc <= tc + 5'd1;
      end else begin
        tx_q <= ~brk;
      end
    end
  end

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk && empty && os_en) |=> tx_q);
  p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk && empty && os_en) |=> !tx_q);
  p_ext_stop_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext && is_stop) |-> (tc < 5'd14));
  p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !os_en |=> $stable(tx_q));
endmodule

// File: rtl/rx_sync2async.sv
module rx_sync2async
  import rs2a_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int K_NORM = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_in,
  input  logic       os_en,
  input  logic [1:0] len_sel,
  input  logic       ext_mode,
  input  logic       bypass,
  output logic       ser_out,
  output logic       overrun
);
  logic [1:0]        n_push;
  logic [MAXPAY-1:0] d0, d1, rd_data;
  logic              brk, pop, empty, tx_q;

  rs2a_deframer u_df (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .len_sel(len_sel), .bypass(bypass), .n_push(n_push), .d0(d0), .d1(d1),
    .brk(brk)
  );

  rs2a_fifo #(.W(MAXPAY), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .n_push(n_push), .d0(d0), .d1(d1), .pop(pop),
    .rd_data(rd_data), .empty(empty), .overrun(overrun)
  );

  rs2a_tx #(.K_NORM(K_NORM)) u_tx (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .ext(ext_mode), .len_sel(len_sel),
    .empty(empty), .rd_data(rd_data), .brk(brk), .pop(pop), .tx_q(tx_q)
  );

  assign ser_out = bypass ? bit_in : tx_q;
endmodule

// File: tb/rx_sync2async_tb_top.sv
module rx_sync2async_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KN = 8;

  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, bit_in = 1'b1, os_en = 1'b1;
  logic [1:0] len_sel = 2'd0;
  logic ext_mode = 1'b0, bypass = 1'b0;
  logic ser_out, overrun;

  int n_chk = 0, n_err = 0, ks = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sync2async dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in), .os_en(os_en),
    .len_sel(len_sel), .ext_mode(ext_mode), .bypass(bypass),
    .ser_out(ser_out), .overrun(overrun)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(posedge clk); #1 bit_in = b; bit_stb = 1'b1;
    @(posedge clk); #1 bit_stb = 1'b0;
    repeat (14) @(posedge clk);
  endtask

  task automatic send_char(input logic [8:0] p, input bit with_stop);
    int pl = int'(len_sel) + 6;
    send_bit(1'b0);
    for (int i = 0; i < pl; i++) send_bit(p[i]);
    if (with_stop) send_bit(1'b1);
  endtask

  task automatic watch(input int ncyc, input logic lvl, input string tag);
    int bad = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (ser_out !== lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  // waveform check with bit lengths computed from R4/R5
  task automatic expect_chars(input int cnt, input bit b2b, input string tag);
    int pl = int'(len_sel) + 6;
    for (int k = 0; k < cnt; k++) begin
      logic [8:0] p = exp_q.pop_front();
      int bad = 0;
      bit have = 1'b0;
      if (k == 0 || !b2b) begin
        int w = 0;
        @(negedge clk);
        while (ser_out !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
        if (ser_out !== 1'b0) begin
          check(1'b0, {tag, " start not seen"}, 1, 0);
          return;
        end
        have = 1'b1;
      end
      for (int j = 0; j < pl + 2; j++) begin
        logic lvl = (j == 0) ? 1'b0 : (j == pl + 1) ? 1'b1 : p[j-1];
        int len;
        if (ext_mode) len = (j == pl + 1) ? 14 : 16;
        else len = (ks == KN - 1) ? 15 : 16;
        if (!ext_mode) ks = (ks + 1) % KN;
        for (int c = 0; c < len; c++) begin
          if (have) have = 1'b0;
          else @(negedge clk);
          if (ser_out !== lvl) bad++;
        end
      end
      check(bad == 0, $sformatf("%s char %0d data %0h", tag, k, p), bad, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(ser_out === 1'b1, "R1 reset mark", int'(ser_out), 1);
    check(overrun === 1'b0, "R1 reset overrun", int'(overrun), 0);

    // R2 R3 R4 R5 R6: sweep lengths and modes, three stop-deleted chars then one with stop
    for (int cl = 0; cl < 4; cl++) begin
      for (int ex = 0; ex < 2; ex++) begin
        int pl = cl + 6;
        logic [8:0] v [4];
        len_sel = 2'(cl); ext_mode = ex[0];
        for (int i = 0; i < 4; i++) begin
          v[i] = 9'((i * 53 + cl * 37 + ex * 91 + 5) & ((1 << pl) - 1)) | 9'd1;
          exp_q.push_back(v[i]);
        end
        fork
          begin
            for (int i = 0; i < 4; i++) send_char(v[i], i == 3);
            repeat (3) send_bit(1'b1);
          end
          expect_chars(4, 1'b1, ex ? "R2 R3 R5 R6" : "R2 R3 R4 R6");
        join
        watch(40, 1'b1, "R1 idle after burst");
      end
    end

    // R8: zero char with missing stop, then a char containing a high bit
    len_sel = 2'd0; ext_mode = 1'b0;
    exp_q.push_back(9'h000); exp_q.push_back(9'h02A);
    fork
      begin send_char(9'h000, 1'b0); send_char(9'h02A, 1'b1); repeat (3) send_bit(1'b1); end
      expect_chars(2, 1'b1, "R8 deferred zero");
    join

    // R8: zero char with missing stop, then zero char with stop (double push)
    exp_q.push_back(9'h000); exp_q.push_back(9'h000);
    fork
      begin send_char(9'h000, 1'b0); send_char(9'h000, 1'b1); repeat (3) send_bit(1'b1); end
      expect_chars(2, 1'b1, "R8 double push");
    join
    watch(40, 1'b1, "R8 idle");

    // R7: break of 2N-1 lows
    fork
      repeat (14) send_bit(1'b0);
      watch(14 * 16, 1'b1, "R7 nothing before break");
    join
    send_bit(1'b0);
    @(negedge clk);
    check(ser_out === 1'b0, "R7 break low", int'(ser_out), 0);
    fork
      repeat (10) send_bit(1'b0);
      watch(10 * 16, 1'b0, "R7 break held without stop");
    join
    send_bit(1'b1);
    @(negedge clk);
    check(ser_out === 1'b1, "R7 break release", int'(ser_out), 1);
    fork
      repeat (8) send_bit(1'b1);
      watch(8 * 16, 1'b1, "R7 nothing emitted after break");
    join

    // R10: bypass follows input, frames nothing
    bypass = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < 24; i++) begin
        logic v = (i % 5 == 1) || (i % 7 == 3);
        @(posedge clk); #1 bit_in = v; bit_stb = 1'b1;
        @(negedge clk); if (ser_out !== v) bad++;
        @(posedge clk); #1 bit_stb = 1'b0;
      end
      check(bad == 0, "R10 bypass pass-through", bad, 0);
    end
    @(posedge clk); #1 bit_in = 1'b1; bypass = 1'b0;
    watch(300, 1'b1, "R10 nothing queued in bypass");

    // R9 R11: fill queue with output ticks stopped
    os_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      logic [8:0] v = 9'((i * 29 + 3) & 63) | 9'd2;
      if (i < 4) exp_q.push_back(v);
      send_char(v, 1'b1);
      if (i == 3) check(overrun === 1'b0, "R9 no overrun at four", int'(overrun), 0);
    end
    send_bit(1'b1);
    check(overrun === 1'b1, "R9 overrun on fifth", int'(overrun), 1);
    check(ser_out === 1'b1, "R11 no output without ticks", int'(ser_out), 1);
    fork
      expect_chars(4, 1'b1, "R9 R11 drain first four");
      begin @(posedge clk); #1 os_en = 1'b1; end
    join
    watch(60, 1'b1, "R9 fifth char dropped");
    check(overrun === 1'b1, "R9 overrun sticky", int'(overrun), 1);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule